// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded DAC Front End

This block is the digital side of a 10-bit converter attached to an 8-bit processor bus. The code is left-justified in the processor's 16-bit word, so the processor writes it in two byte cycles, most-significant byte first. The first write fills the whole input latch: the byte goes to code bits 9..2, and its top two bits are also copied into bits 1..0. The second write replaces only bits 1..0, again from bus bits 7..6. A second register, the output register, holds the code that reaches the converter. Only the output register drives the converter.

Data moves from the latch to the output register in one of three ways.
- **Automatic:** the transfer happens on the edge of the completing low-byte write.
- **Processor-strobed:** a transfer strobe given during a bus write performs the transfer, without chip select.
- **External:** the transfer strobe on its own performs the transfer.

In the two strobed modes, many converters can share one strobe and change their outputs together.

A two-state sequencer tracks the byte order.
- **SEQ_WAIT_HI:** entered at reset and after any low-byte write. A high-byte write moves it to SEQ_WAIT_LO. This transition is named *take_hi*.
- **SEQ_WAIT_LO:** entered after a high-byte write. A low-byte write returns it to SEQ_WAIT_HI and marks the pair as complete. This transition is named *take_lo*. A further high-byte write keeps it in SEQ_WAIT_LO. This transition is named *retake_hi*.

A low-byte write made in SEQ_WAIT_HI is named *stray_lo*. It stays in SEQ_WAIT_HI, updates bits 1..0 and completes no pair.

Top module: `dac_byte_front`

## Requirements
- R1: After reset, `code_out` is 0, `upd` is 0 and the input latch holds 0.
- R2: A write with `sel`=1, `wr`=1 and `hi_byte`=1 loads the latch with {bus[7:0], bus[7:6]}.
- R3: A write with `sel`=1, `wr`=1 and `hi_byte`=0 sets latch bits 1..0 to bus[7:6]. Latch bits 9..2 are unchanged.
- R4: A cycle without both `sel`=1 and `wr`=1 leaves the latch unchanged.
- R5: In mode 2'b00 (automatic), a low-byte write that directly follows a high-byte write loads the merged latch value into the output register on the same edge.
- R6: In automatic mode, a low-byte write that does not follow a high-byte write updates the latch but does not change the output.
- R7: In mode 2'b01 (processor-strobed), the output register loads the latch only in a cycle with `xfer`=1 and `wr`=1. Latch writes alone never change the output.
- R8: In modes 2'b10 and 2'b11 (external), `xfer`=1 alone loads the latch into the output register.
- R9: `upd` is high for exactly the one cycle after each load of the output register. `code_out` changes only in a cycle where `upd` is high.
- R10: In automatic mode, `xfer` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, active high |
| hi_byte | input | 1 | 1 = first (high-byte) write, 0 = second (low-byte) write |
| xfer | input | 1 | Transfer strobe |
| mode | input | 2 | 00 automatic, 01 processor-strobed, 1x external |
| bus | input | 8 | Processor data byte |
| code_out | output | 10 | Output register, the code driving the converter |
| upd | output | 1 | One-cycle pulse after each output register load |

## Verification
Every latch write and every transfer takes effect on the clock edge that samples it. A load then shows in `code_out` together with `upd`, one edge after the stimulus. The scoreboard pushes the expected code before it drives a stimulus that should load. The monitor samples 5 ns after each rising edge and, whenever `upd` is high, pops the expected code and compares it with `code_out`. Any `upd` with nothing queued counts as a failure. Stimuli that must not load the output are followed by a check, two cycles later, that the queue is empty. The contents of the latch are brought out by a later strobed transfer.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

    typedef enum logic [1:0] {
        XFER_AUTO = 2'b00,
        XFER_CPU  = 2'b01,
        XFER_EXT  = 2'b10,
        XFER_EXT2 = 2'b11
    } xfer_mode_e;

    typedef enum logic {
        SEQ_WAIT_HI = 1'b0,
        SEQ_WAIT_LO = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
    import dac_front_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr,
    input  logic       hi_byte,
    output logic       ld_hi,
    output logic       ld_lo,
    output logic       pair_done,
    output seq_state_e state
);

    seq_state_e state_nx;
    logic       bus_wr;

    assign bus_wr = sel && wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_WAIT_HI;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_WAIT_HI: if (bus_wr && hi_byte) state_nx = SEQ_WAIT_LO;
            SEQ_WAIT_LO: if (bus_wr && !hi_byte) state_nx = SEQ_WAIT_HI;
            default:     state_nx = SEQ_WAIT_HI;
        endcase
    end

    always_comb begin
        ld_hi     = bus_wr && hi_byte;
        ld_lo     = bus_wr && !hi_byte;
        pair_done = 1'b0;
        unique case (state)
            SEQ_WAIT_HI: pair_done = 1'b0;
            SEQ_WAIT_LO: pair_done = ld_lo;
            default:     pair_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/dac_in_latch.sv
module dac_in_latch #(
    parameter int CODE_W = 10,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [BUS_W-1:0]  bus,
    output logic [CODE_W-1:0] latch_q,
    output logic [CODE_W-1:0] latch_nx
);

    localparam int LO_W = CODE_W - BUS_W;

    always_comb begin
        latch_nx = latch_q;
        if (ld_hi) begin
            latch_nx = {bus, bus[BUS_W-1 -: LO_W]};
        end else if (ld_lo) begin
            latch_nx[LO_W-1:0] = bus[BUS_W-1 -: LO_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_nx;
        end
    end

endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg
    import dac_front_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_mode_e        mode,
    input  logic              pair_done,
    input  logic              xfer,
    input  logic              wr,
    input  logic [CODE_W-1:0] latch_q,
    input  logic [CODE_W-1:0] latch_nx,
    output logic [CODE_W-1:0] code_out,
    output logic              upd
);

    logic              load;
    logic [CODE_W-1:0] src;

    always_comb begin
        load = 1'b0;
        src  = latch_q;
        unique case (mode)
            XFER_AUTO: begin
                load = pair_done;
                src  = latch_nx;
            end
            XFER_CPU:  load = xfer && wr;
            XFER_EXT,
            XFER_EXT2: load = xfer;
            default:   load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_out <= '0;
            upd      <= 1'b0;
        end else begin
            upd <= load;
            if (load) code_out <= src;
        end
    end

endmodule

// File: rtl/dac_byte_front.sv
module dac_byte_front
    import dac_front_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              hi_byte,
    input  logic              xfer,
    input  logic [1:0]        mode,
    input  logic [BUS_W-1:0]  bus,
    output logic [CODE_W-1:0] code_out,
    output logic              upd
);

    logic              ld_hi;
    logic              ld_lo;
    logic              pair_done;
    seq_state_e        seq_state;
    logic [CODE_W-1:0] latch_q;
    logic [CODE_W-1:0] latch_nx;
    xfer_mode_e        mode_e;

    assign mode_e = xfer_mode_e'(mode);

    dac_wr_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr        (wr),
        .hi_byte   (hi_byte),
        .ld_hi     (ld_hi),
        .ld_lo     (ld_lo),
        .pair_done (pair_done),
        .state     (seq_state)
    );

    dac_in_latch #(.CODE_W(CODE_W), .BUS_W(BUS_W)) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_hi    (ld_hi),
        .ld_lo    (ld_lo),
        .bus      (bus),
        .latch_q  (latch_q),
        .latch_nx (latch_nx)
    );

    dac_out_reg #(.CODE_W(CODE_W)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .pair_done (pair_done),
        .xfer      (xfer),
        .wr        (wr),
        .latch_q   (latch_q),
        .latch_nx  (latch_nx),
        .code_out  (code_out),
        .upd       (upd)
    );

endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk
    import dac_front_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic              hi_byte,
    input logic              xfer,
    input logic [1:0]        mode,
    input logic [CODE_W-1:0] code_out,
    input logic              upd,
    input logic [CODE_W-1:0] latch_q,
    input seq_state_e        seq_state
);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> $stable(latch_q));

    assert_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !hi_byte) |=> (latch_q[CODE_W-1:2] == $past(latch_q[CODE_W-1:2])));

    assert_auto_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && sel && wr && !hi_byte && seq_state == SEQ_WAIT_LO) |=> upd);

    assert_auto_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !(sel && wr && !hi_byte)) |=> !upd);

    assert_cpu_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !(xfer && wr)) |=> !upd);

    assert_ext_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && xfer) |=> upd);

    assert_code_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(code_out));

endmodule

bind dac_byte_front dac_front_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr        (wr),
    .hi_byte   (hi_byte),
    .xfer      (xfer),
    .mode      (mode),
    .code_out  (code_out),
    .upd       (upd),
    .latch_q   (latch_q),
    .seq_state (seq_state)
);

// File: tb/test_dac_byte_front.sv
`timescale 1ns/1ps
module test_dac_byte_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic       hi_byte = 1'b0;
    logic       xfer = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] bus = 8'h00;
    logic [9:0] code_out;
    logic       upd;

    int         n_total = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    dac_byte_front i_dac_byte_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr       (wr),
        .hi_byte  (hi_byte),
        .xfer     (xfer),
        .mode     (mode),
        .bus      (bus),
        .code_out (code_out),
        .upd      (upd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_load(input logic [9:0] code, input string tag);
        exp_q.push_back(code);
        tag_q.push_back(tag);
    endtask

    task automatic pulse(input logic s, input logic w, input logic h,
                         input logic x, input logic [7:0] d);
        @(negedge clk);
        sel = s; wr = w; hi_byte = h; xfer = x; bus = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; hi_byte = 1'b0; xfer = 1'b0; bus = 8'h00;
    endtask

    task automatic drained(input string tag);
        repeat (2) @(negedge clk);
        chk({tag, " queue drained"}, exp_q.size(), 0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
    endtask

    // Monitor / scoreboard
    logic prev_upd = 1'b0;
    always begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            if (prev_upd && upd) begin
                n_total++; n_fail++;
                $display("FAIL R9 upd wider than one cycle actual=1 expected=0");
            end
            if (upd) begin
                if (exp_q.size() == 0) begin
                    n_total++; n_fail++;
                    $display("FAIL R9 unexpected load actual=0x%0h expected=no load", code_out);
                end else begin
                    chk(tag_q.pop_front(), int'(code_out), int'(exp_q.pop_front()));
                end
            end
            prev_upd = upd;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 code_out in reset", int'(code_out), 0);
        chk("R1 upd in reset", int'(upd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code_out after reset", int'(code_out), 0);

        // Processor-strobed mode
        set_mode(2'b01);
        expect_load(10'h000, "R1 latch zero after reset");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        drained("R1");

        pulse(1'b1, 1'b1, 1'b1, 1'b0, 8'hA5);
        drained("R7 latch write no output change");
        chk("R7 code_out held", int'(code_out), 0);
        expect_load(10'h296, "R2 high byte load");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        drained("R2");
        @(negedge clk);
        chk("R9 upd one cycle", int'(upd), 0);

        pulse(1'b1, 1'b1, 1'b0, 1'b0, 8'h40);
        drained("R7 low write no output change");
        expect_load(10'h295, "R3 low pair overwrite");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        drained("R3");

        pulse(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
        pulse(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        drained("R7 xfer without wr");
        expect_load(10'h295, "R4 ignored writes");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        drained("R4");

        // Automatic mode
        set_mode(2'b00);
        pulse(1'b1, 1'b1, 1'b1, 1'b0, 8'h3C);
        drained("R5 high write alone");
        expect_load(10'h0F3, "R5 auto transfer");
        pulse(1'b1, 1'b1, 1'b0, 1'b0, 8'hC0);
        drained("R5");
        chk("R5 code_out", int'(code_out), 10'h0F3);

        pulse(1'b1, 1'b1, 1'b0, 1'b0, 8'h80);
        drained("R6 stray low write");
        chk("R6 code_out held", int'(code_out), 10'h0F3);

        pulse(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        drained("R10 xfer in auto");
        chk("R10 code_out held", int'(code_out), 10'h0F3);

        set_mode(2'b01);
        expect_load(10'h0F2, "R6 latch took stray pair");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        drained("R6");

        // External mode
        set_mode(2'b10);
        pulse(1'b1, 1'b1, 1'b1, 1'b0, 8'h01);
        drained("R8 write no output change");
        expect_load(10'h004, "R8 external strobe mode 10");
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        drained("R8 mode 10");

        set_mode(2'b11);
        pulse(1'b1, 1'b1, 1'b1, 1'b0, 8'hFF);
        expect_load(10'h3FF, "R8 external strobe mode 11");
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        drained("R8 mode 11");
        chk("R8 code_out", int'(code_out), 10'h3FF);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule